// File: doc/BRIEF.md
# External Interrupt Sense Controller

This block converts a single asynchronous interrupt pin into an interrupt request for an interrupt controller. The pin is first brought into the system clock domain through a chain of flip-flops. A change is then recognised by comparing the newest synchronised sample with the sample taken one clock earlier. A 2-bit sense field selects one of four conditions: low level, any change, falling edge or rising edge.

In the three edge conditions, a qualifying change sets a sticky flag. The flag holds the request until the interrupt controller pulses an acknowledge. In low-level mode nothing is latched, and the request simply follows the synchronised pin. The request leaves the block only when both a global enable and this source's mask bit are set. The flag itself keeps latching while the output is gated off.

Software sees a 4-bit control word. The sense field sits in bits [1:0]. Bits [3:2] are reserved and always read back as zero.

Top module: `extint_sense`

## Requirements
- R1: After reset the sense field is 00 (low level), the control readback is 4'b0000 and the edge flag is clear, so with the pin high and both enables set there is no request.
- R2: A write stores writeData[1:0] as the sense field, and it is visible on ctrlRead[1:0] after the next clock edge. ctrlRead[3:2] always read 0, whatever was written to them.
- R3: irqReq is asserted only while both globalEn and maskEn are 1. An edge flag latched while either enable is 0 is kept, and it drives irqReq as soon as both enables are 1.
- R4: With sense 00, irqReq is 1 while the synchronised pin is low and 0 while it is high. Acknowledge has no effect in this mode, and the edge flag never sets in this mode.
- R5: With sense 11, a rising edge of the synchronised pin sets the flag. A falling edge does not.
- R6: With sense 10, a falling edge sets the flag. A rising edge does not.
- R7: With sense 01, both rising and falling edges set the flag.
- R8: An ack pulse clears the edge flag. If a qualifying edge is detected in the same cycle as ack, the flag stays set.
- R9: In an edge mode, a pin pulse lasting two or more clock periods is always detected.
- R10: With the default two synchronizer stages, a pin change shows on irqReq after 2 rising clock edges in low-level mode and after 3 in edge modes.
- R11: Rewriting the sense field while maskEn is 0 and the pin is steady sets no flag, so no request appears when the mask is set again.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| pinAsync | input | 1 | External interrupt pin, asynchronous to clk |
| writeEn | input | 1 | Control word write strobe |
| writeData | input | 4 | Control word write data; [1:0] is the sense field |
| ctrlRead | output | 4 | Control word readback; [3:2] read as zero |
| globalEn | input | 1 | Global interrupt enable |
| maskEn | input | 1 | Per-source interrupt mask bit |
| ack | input | 1 | Acknowledge pulse from the interrupt controller |
| irqReq | output | 1 | Gated interrupt request |

## Verification
A wrong internal state shows up on irqReq within at most three clock edges of the pin change that should have set it. A flag that fails to set leaves irqReq low at that point. A flag that fails to clear, or that sets on the wrong polarity, leaves irqReq high after an acknowledge or after an ignored edge. A corrupted sense register shows immediately on ctrlRead, and it also changes which pin edges raise irqReq. Acknowledge, enable and mode changes are applied at known clock positions, so every divergence can be tied to a single edge.

// File: rtl/extint_pkg.sv
package extint_pkg;

  typedef enum logic [1:0] {
    SENSE_LOW  = 2'b00,
    SENSE_ANY  = 2'b01,
    SENSE_FALL = 2'b10,
    SENSE_RISE = 2'b11
  } senseMode_e;

  typedef struct packed {
    logic armRise;
    logic armFall;
    logic clearFlag;
  } dpStrobe_t;

endpackage

// File: rtl/extint_datapath.sv
module extint_datapath
  import extint_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      pinAsync,
  input  dpStrobe_t strobe,
  output logic      pinLow,
  output logic      edgeFlag
);

  logic [SYNC_STAGES-1:0] syncQ;
  logic pinSync;
  logic prevQ;
  logic riseHit;
  logic fallHit;
  logic setHit;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) syncQ[0] <= 1'b1;
    else       syncQ[0] <= pinAsync;
  end

  generate
    for (genvar i = 1; i < SYNC_STAGES; i++) begin : g_sync
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) syncQ[i] <= 1'b1;
        else       syncQ[i] <= syncQ[i-1];
      end
    end
  endgenerate

  assign pinSync = syncQ[SYNC_STAGES-1];
  assign pinLow  = ~pinSync;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) prevQ <= 1'b1;
    else       prevQ <= pinSync;
  end

  assign riseHit = pinSync & ~prevQ;
  assign fallHit = ~pinSync & prevQ;
  assign setHit  = (strobe.armRise & riseHit) | (strobe.armFall & fallHit);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                 edgeFlag <= 1'b0;
    else if (setHit)           edgeFlag <= 1'b1;
    else if (strobe.clearFlag) edgeFlag <= 1'b0;
  end

  // R8
  set_wins_chk: assert property (@(posedge clk) disable iff (!rstN)
    (setHit && strobe.clearFlag) |=> edgeFlag);

  // R8
  ack_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.clearFlag && !setHit) |=> !edgeFlag);

  // R4
  no_arm_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!edgeFlag && !strobe.armRise && !strobe.armFall) |=> !edgeFlag);

  // R5
  rise_detect_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.armRise && $rose(pinSync)) |=> edgeFlag);

  // R6
  fall_detect_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.armFall && $fell(pinSync)) |=> edgeFlag);

endmodule

// File: rtl/extint_ctrl.sv
module extint_ctrl
  import extint_pkg::*;
#(
  parameter int CTRL_W = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              writeEn,
  input  logic [CTRL_W-1:0] writeData,
  input  logic              globalEn,
  input  logic              maskEn,
  input  logic              ack,
  input  logic              pinLow,
  input  logic              edgeFlag,
  output dpStrobe_t         strobe,
  output logic [CTRL_W-1:0] ctrlRead,
  output logic              irqReq
);

  localparam int SENSE_W = 2;
  localparam int RES_W   = CTRL_W - SENSE_W;

  senseMode_e senseReg;
  logic levelSel;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)        senseReg <= SENSE_LOW;
    else if (writeEn) senseReg <= senseMode_e'(writeData[SENSE_W-1:0]);
  end

  assign ctrlRead = {{RES_W{1'b0}}, senseReg};

  always_comb begin
    strobe.armRise   = (senseReg == SENSE_RISE) || (senseReg == SENSE_ANY);
    strobe.armFall   = (senseReg == SENSE_FALL) || (senseReg == SENSE_ANY);
    strobe.clearFlag = ack;
  end

  assign levelSel = (senseReg == SENSE_LOW);
  assign irqReq   = globalEn & maskEn & (levelSel ? pinLow : edgeFlag);

  // R2
  readback_chk: assert property (@(posedge clk) disable iff (!rstN)
    writeEn |=> ctrlRead[SENSE_W-1:0] == $past(writeData[SENSE_W-1:0]));

  // R2
  sense_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !writeEn |=> $stable(ctrlRead));

endmodule

// File: rtl/extint_sense.sv
module extint_sense
  import extint_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int CTRL_W      = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              pinAsync,
  input  logic              writeEn,
  input  logic [CTRL_W-1:0] writeData,
  output logic [CTRL_W-1:0] ctrlRead,
  input  logic              globalEn,
  input  logic              maskEn,
  input  logic              ack,
  output logic              irqReq
);

  dpStrobe_t strobe;
  logic pinLow;
  logic edgeFlag;

  extint_ctrl #(.CTRL_W(CTRL_W)) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .writeEn  (writeEn),
    .writeData(writeData),
    .globalEn (globalEn),
    .maskEn   (maskEn),
    .ack      (ack),
    .pinLow   (pinLow),
    .edgeFlag (edgeFlag),
    .strobe   (strobe),
    .ctrlRead (ctrlRead),
    .irqReq   (irqReq)
  );

  extint_datapath #(.SYNC_STAGES(SYNC_STAGES)) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .pinAsync(pinAsync),
    .strobe  (strobe),
    .pinLow  (pinLow),
    .edgeFlag(edgeFlag)
  );

endmodule

// File: tb/test_extint_sense.sv
module test_extint_sense;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic pinAsync = 1'b1;
  logic writeEn = 1'b0;
  logic [3:0] writeData = 4'h0;
  logic [3:0] ctrlRead;
  logic globalEn = 1'b1;
  logic maskEn = 1'b1;
  logic ack = 1'b0;
  logic irqReq;

  int nCompared = 0;
  int nMismatched = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  extint_sense i_extint_sense (
    .clk(clk), .rstN(rstN), .pinAsync(pinAsync), .writeEn(writeEn),
    .writeData(writeData), .ctrlRead(ctrlRead), .globalEn(globalEn),
    .maskEn(maskEn), .ack(ack), .irqReq(irqReq)
  );

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic checkBit(input logic got, input logic exp, input string req);
    nCompared++;
    if (got !== exp) begin
      nMismatched++;
      $display("FAIL %s: irqReq=%b expected %b", req, got, exp);
    end
  endtask

  task automatic checkCtrl(input logic [3:0] exp, input string req);
    nCompared++;
    if (ctrlRead !== exp) begin
      nMismatched++;
      $display("FAIL %s: ctrlRead=%b expected %b", req, ctrlRead, exp);
    end
  endtask

  task automatic writeCtrl(input logic [3:0] val);
    writeData = val; writeEn = 1'b1;
    tick(1);
    writeEn = 1'b0;
  endtask

  task automatic pulseAck();
    ack = 1'b1;
    tick(1);
    ack = 1'b0;
  endtask

  task automatic t_reset();
    tick(3);
    checkBit(irqReq, 1'b0, "R1");
    checkCtrl(4'b0000, "R1");
  endtask

  task automatic t_level();
    pinAsync = 1'b0;
    tick(1); checkBit(irqReq, 1'b0, "R10 level latency");
    tick(1); checkBit(irqReq, 1'b1, "R4 low asserts");
    pulseAck(); checkBit(irqReq, 1'b1, "R4 ack ignored");
    pinAsync = 1'b1;
    tick(2); checkBit(irqReq, 1'b0, "R4 high releases");
  endtask

  task automatic t_gating();
    pinAsync = 1'b0; tick(2);
    globalEn = 1'b0; #1 checkBit(irqReq, 1'b0, "R3 global off");
    globalEn = 1'b1; maskEn = 1'b0; #1 checkBit(irqReq, 1'b0, "R3 mask off");
    maskEn = 1'b1; #1 checkBit(irqReq, 1'b1, "R3 both on");
    tick(1);
    pinAsync = 1'b1; tick(3);
  endtask

  task automatic t_rise();
    writeCtrl(4'b1111);
    checkCtrl(4'b0011, "R2 reserved zero");
    checkBit(irqReq, 1'b0, "R11 mode switch quiet");
    pinAsync = 1'b0; tick(3); checkBit(irqReq, 1'b0, "R5 fall ignored");
    pinAsync = 1'b1;
    tick(2); checkBit(irqReq, 1'b0, "R10 edge latency");
    tick(1); checkBit(irqReq, 1'b1, "R5 rise sets");
    pinAsync = 1'b0; tick(3); checkBit(irqReq, 1'b1, "R5 flag held");
    pulseAck(); checkBit(irqReq, 1'b0, "R8 ack clears");
  endtask

  task automatic t_fall();
    writeCtrl(4'b0110);
    checkCtrl(4'b0010, "R2 readback");
    pinAsync = 1'b1; tick(3); checkBit(irqReq, 1'b0, "R6 rise ignored");
    pinAsync = 1'b0; tick(3); checkBit(irqReq, 1'b1, "R6 fall sets");
    pulseAck(); checkBit(irqReq, 1'b0, "R8 ack clears");
  endtask

  task automatic t_any();
    writeCtrl(4'b0001);
    pinAsync = 1'b1; tick(3); checkBit(irqReq, 1'b1, "R7 rise sets");
    pulseAck(); checkBit(irqReq, 1'b0, "R8 ack clears");
    pinAsync = 1'b0; tick(2);
    ack = 1'b1; tick(1); ack = 1'b0;
    checkBit(irqReq, 1'b1, "R8 edge beats ack");
    pulseAck(); checkBit(irqReq, 1'b0, "R8 ack clears");
  endtask

  task automatic t_masked_edge();
    maskEn = 1'b0;
    pinAsync = 1'b1; tick(3); checkBit(irqReq, 1'b0, "R3 masked");
    maskEn = 1'b1; #1 checkBit(irqReq, 1'b1, "R3 latched flag");
    tick(1); pulseAck();
  endtask

  task automatic t_mode_change();
    maskEn = 1'b0;
    writeCtrl(4'b0011);
    writeCtrl(4'b0010);
    tick(3);
    maskEn = 1'b1; #1 checkBit(irqReq, 1'b0, "R11 no spurious");
    tick(1);
  endtask

  task automatic t_pulse();
    pinAsync = 1'b0; tick(2);
    pinAsync = 1'b1; tick(3);
    checkBit(irqReq, 1'b1, "R9 short pulse caught");
    pulseAck(); checkBit(irqReq, 1'b0, "R8 ack clears");
  endtask

  task automatic t_reset_mid();
    pinAsync = 1'b0; tick(3); checkBit(irqReq, 1'b1, "R6 fall sets");
    pinAsync = 1'b1; tick(3);
    rstN = 1'b0; tick(1); rstN = 1'b1; tick(1);
    checkBit(irqReq, 1'b0, "R1 flag cleared");
    checkCtrl(4'b0000, "R1 sense reset");
  endtask

  initial begin
    tick(2);
    rstN = 1'b1;
    t_reset();
    t_level();
    t_gating();
    t_rise();
    t_fall();
    t_any();
    t_masked_edge();
    t_mode_change();
    t_pulse();
    t_reset_mid();
    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nCompared, nMismatched);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      nCompared++;
      nMismatched++;
      $display("FAIL watchdog: done=0 expected 1");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nCompared, nMismatched);
      $finish;
    end
  end

endmodule